// File: doc/BRIEF.md
# Iterative 8x8 Multiply and 16/8 Divide Unit

This block is the arithmetic helper of a small 8-bit controller core. It works in two modes. In multiply mode it forms the unsigned product of two bytes and returns it as a high byte and a low byte. In divide mode it divides an unsigned 16-bit dividend by an 8-bit divisor and returns an 8-bit quotient and an 8-bit remainder. Each mode also updates a zero flag, a sign flag and a carry flag.

An operation starts on a one-clock `start` pulse, with `op_sel` picking the mode. The unit first spends a fixed number of decode clocks. It then runs one clock per iteration: shift-and-add for multiply, restoring shift-and-subtract for divide. While it works it holds `busy`. When the results and flags become valid it raises `done` for one clock. The result and flag outputs keep their values until the next operation finishes, so the core can read them whenever it suits it.

The multiply zero flag copies a quirk of the core this unit serves. The flag is set whenever bit 0 of the product is 0, even when the full product is nonzero. Software written for that core depends on this.

Top module: `muldiv_unit`

## Requirements
- R1: In multiply mode (`op_sel` = 0) the unsigned product `op_a * op_b` is returned with bits 15..8 on `res_hi` and bits 7..0 on `res_lo`.
- R2: After a multiply, `flag_z` is 1 exactly when bit 0 of the product is 0. This holds even when the product is nonzero.
- R3: After a multiply, `flag_s` equals bit 15 of the product (bit 7 of `res_hi`), and `flag_c` is 0.
- R4: In divide mode (`op_sel` = 1), with dividend {`op_hi`,`op_a`} and divisor `op_b`, and with `op_hi` < `op_b`, `res_lo` is the quotient and `res_hi` is the remainder.
- R5: After a divide, `flag_z` is 1 exactly when `res_lo` (the quotient) is 0, and `flag_s` equals bit 7 of the quotient.
- R6: A divide with `op_hi` >= `op_b` is an overflow. Division by zero is one such case. The unit still finishes in normal time, sets `flag_c` = 1, returns quotient 0xFF and returns the low dividend byte `op_a` as the remainder. For a divide without overflow, `flag_c` is 0.
- R7: A start accepted at clock edge k holds `busy` high for the 10 cycles after edge k: 2 decode clocks plus 8 iteration clocks. `done` is high only in the cycle after edge k+10, and `busy` is low in that cycle.
- R8: A `start` sampled while `busy` is high is ignored. The operation in flight runs on unchanged, and its results come from its own operands.
- R9: A synchronous reset returns the unit to idle, with `busy` and `done` low, and clears all result bytes and flags to 0. This also applies in the middle of an operation.
- R10: The result and flag outputs change only in the cycle where `done` is high. At all other times they hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-clock request to begin an operation |
| op_sel | input | 1 | Mode select: 0 = multiply, 1 = divide |
| op_a | input | 8 | Multiplicand, or low byte of the dividend |
| op_b | input | 8 | Multiplier, or the divisor |
| op_hi | input | 8 | High byte of the dividend (used in divide mode only) |
| busy | output | 1 | High while an operation is decoding or iterating |
| done | output | 1 | One-clock pulse when results and flags are valid |
| res_hi | output | 8 | Product high byte, or the remainder |
| res_lo | output | 8 | Product low byte, or the quotient |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_c | output | 1 | Carry / overflow flag |

## Verification
Several behaviours are checked by properties on every clock:
- `done` is a single-cycle pulse that follows `busy` and never overlaps it.
- The outputs hold still outside `done`.
- A start arriving during an iteration does not disturb the iteration count.
- The partial remainder stays below the divisor while a divide without overflow iterates.
- The multiply zero flag tracks the inverse of the product's bit 0.
- An overflowing divide saturates the quotient.

The numeric correctness of products and quotients, the exact 10-cycle latency, back-to-back launches right after `done`, and a reset in the middle of an operation can only be shown by the bench's scenarios. The bench compares every cycle against a behavioural model that uses the language's own `*`, `/` and `%` operators.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DEC  = 2'd1,
      ST_EXE  = 2'd2
   } seq_state_t;

   typedef enum logic {
      OP_MUL = 1'b0,
      OP_DIV = 1'b1
   } mdu_op_t;
endpackage

// File: rtl/muldiv_seq.sv
module muldiv_seq
   import muldiv_pkg::*;
#(
   parameter int ITER    = 8,
   parameter int DEC_CYC = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic busy,
   output logic load,
   output logic step,
   output logic last,
   output logic done
);
   localparam int CMAX = (ITER > DEC_CYC) ? ITER : DEC_CYC;
   localparam int CW   = $clog2(CMAX + 1);

   if (ITER < 1) begin : g_bad_iter
      $error("muldiv_seq: ITER must be at least 1");
   end
   if (DEC_CYC < 1) begin : g_bad_dec
      $error("muldiv_seq: DEC_CYC must be at least 1");
   end

   seq_state_t    state_q;
   logic [CW-1:0] cnt_q;

   assign busy = (state_q != ST_IDLE);
   assign load = (state_q == ST_IDLE) && start;
   assign step = (state_q == ST_EXE);
   assign last = step && (cnt_q == CW'(ITER - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (start) state_q <= ST_DEC;
            end
            ST_DEC: begin
               if (cnt_q == CW'(DEC_CYC - 1)) begin
                  state_q <= ST_EXE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_EXE: begin
               if (cnt_q == CW'(ITER - 1)) begin
                  state_q <= ST_IDLE;
                  cnt_q   <= '0;
                  done    <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               state_q <= ST_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   p_done_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
      done |-> ($past(busy) && !busy));
   p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
      (start && step && !last) |=> (step && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/muldiv_mul_dp.sv
module muldiv_mul_dp #(
   parameter int W = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic           step,
   input  logic [W-1:0]   mcand,
   input  logic [W-1:0]   mplier,
   output logic [2*W-1:0] prod_nxt
);
   logic [W-1:0] mcand_q, ph_q, pl_q;
   logic [W:0]   sum;

   assign sum      = {1'b0, ph_q} + (pl_q[0] ? {1'b0, mcand_q} : '0);
   assign prod_nxt = {sum[W:1], sum[0], pl_q[W-1:1]};

   always_ff @(posedge clk) begin
      if (rst) begin
         mcand_q <= '0;
         ph_q    <= '0;
         pl_q    <= '0;
      end else if (load) begin
         mcand_q <= mcand;
         ph_q    <= '0;
         pl_q    <= mplier;
      end else if (step) begin
         ph_q <= sum[W:1];
         pl_q <= {sum[0], pl_q[W-1:1]};
      end
   end

   p_mcand_hold_r1: assert property (@(posedge clk) disable iff (rst)
      (!load) |=> $stable(mcand_q));
endmodule

// File: rtl/muldiv_div_dp.sv
module muldiv_div_dp #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] dvd_hi,
   input  logic [W-1:0] dvd_lo,
   input  logic [W-1:0] dvs,
   output logic [W-1:0] quo_nxt,
   output logic [W-1:0] rem_nxt,
   output logic         ovf
);
   logic [W-1:0] rem_q, qs_q, dvs_q, lo_q;
   logic         ovf_q;
   logic [W:0]   trial, diff;
   logic         ge;
   logic [W-1:0] rem_it, qs_it;

   assign trial   = {rem_q, qs_q[W-1]};
   assign ge      = (trial >= {1'b0, dvs_q});
   assign diff    = trial - {1'b0, dvs_q};
   assign rem_it  = ge ? diff[W-1:0] : trial[W-1:0];
   assign qs_it   = {qs_q[W-2:0], ge};
   assign quo_nxt = ovf_q ? '1 : qs_it;
   assign rem_nxt = ovf_q ? lo_q : rem_it;
   assign ovf     = ovf_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         rem_q <= '0;
         qs_q  <= '0;
         dvs_q <= '0;
         lo_q  <= '0;
         ovf_q <= 1'b0;
      end else if (load) begin
         rem_q <= dvd_hi;
         qs_q  <= dvd_lo;
         dvs_q <= dvs;
         lo_q  <= dvd_lo;
         ovf_q <= (dvd_hi >= dvs);
      end else if (step) begin
         rem_q <= rem_it;
         qs_q  <= qs_it;
      end
   end

   p_rem_below_dvs_r4: assert property (@(posedge clk) disable iff (rst)
      (step && !ovf_q) |-> (rem_q < dvs_q));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
   import muldiv_pkg::*;
#(
   parameter int DW        = 8,
   parameter int DEC_CYC   = 2,
   parameter bit MUL_Z_LSB = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          op_sel,
   input  logic [DW-1:0] op_a,
   input  logic [DW-1:0] op_b,
   input  logic [DW-1:0] op_hi,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] res_hi,
   output logic [DW-1:0] res_lo,
   output logic          flag_z,
   output logic          flag_s,
   output logic          flag_c
);
   localparam int PW = 2 * DW;

   if (DW < 2) begin : g_bad_dw
      $error("muldiv_unit: DW must be at least 2");
   end

   logic          load, step, last;
   mdu_op_t       op_q;
   logic [PW-1:0] prod_nxt;
   logic [DW-1:0] quo_nxt, rem_nxt;
   logic          div_ovf, mul_z;

   muldiv_seq #(.ITER(DW), .DEC_CYC(DEC_CYC)) u_seq (
      .clk(clk), .rst(rst), .start(start), .busy(busy),
      .load(load), .step(step), .last(last), .done(done)
   );

   muldiv_mul_dp #(.W(DW)) u_mul (
      .clk(clk), .rst(rst), .load(load), .step(step),
      .mcand(op_a), .mplier(op_b), .prod_nxt(prod_nxt)
   );

   muldiv_div_dp #(.W(DW)) u_div (
      .clk(clk), .rst(rst), .load(load), .step(step),
      .dvd_hi(op_hi), .dvd_lo(op_a), .dvs(op_b),
      .quo_nxt(quo_nxt), .rem_nxt(rem_nxt), .ovf(div_ovf)
   );

   if (MUL_Z_LSB) begin : g_zlsb
      assign mul_z = ~prod_nxt[0];
      p_mul_zero_lsb_r2: assert property (@(posedge clk) disable iff (rst)
         (done && op_q == OP_MUL) |-> (flag_z == ~res_lo[0]));
   end else begin : g_zfull
      assign mul_z = ~|prod_nxt;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         op_q   <= OP_MUL;
         res_hi <= '0;
         res_lo <= '0;
         flag_z <= 1'b0;
         flag_s <= 1'b0;
         flag_c <= 1'b0;
      end else begin
         if (load) op_q <= mdu_op_t'(op_sel);
         if (last) begin
            if (op_q == OP_MUL) begin
               res_hi <= prod_nxt[PW-1:DW];
               res_lo <= prod_nxt[DW-1:0];
               flag_z <= mul_z;
               flag_s <= prod_nxt[PW-1];
               flag_c <= 1'b0;
            end else begin
               res_hi <= rem_nxt;
               res_lo <= quo_nxt;
               flag_z <= ~|quo_nxt;
               flag_s <= quo_nxt[DW-1];
               flag_c <= div_ovf;
            end
         end
      end
   end

   p_results_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (!done) |-> $stable({res_hi, res_lo, flag_z, flag_s, flag_c}));
   p_ovf_saturate_r6: assert property (@(posedge clk) disable iff (rst)
      (done && op_q == OP_DIV && flag_c) |-> (res_lo == '1));
   p_mul_no_carry_r3: assert property (@(posedge clk) disable iff (rst)
      (done && op_q == OP_MUL) |-> !flag_c);
endmodule

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       op_sel = 1'b0;
   logic [7:0] op_a = '0, op_b = '0, op_hi = '0;
   logic       busy, done, flag_z, flag_s, flag_c;
   logic [7:0] res_hi, res_lo;

   int n_chk = 0;
   int n_fail = 0;
   bit ended = 0;

   always #2 clk = ~clk;

   muldiv_unit dut_i (
      .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
      .op_a(op_a), .op_b(op_b), .op_hi(op_hi),
      .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo),
      .flag_z(flag_z), .flag_s(flag_s), .flag_c(flag_c)
   );

   // behavioural reference model, advanced on every rising edge
   int  cd = 0;
   bit  m_done = 0;
   int  m_hi = 0, m_lo = 0;
   bit  m_z = 0, m_s = 0, m_c = 0;
   int  c_a, c_b, c_h;
   bit  c_op;
   bit  m_ovf = 0;

   always @(posedge clk) begin
      if (rst) begin
         cd = 0; m_done = 0; m_hi = 0; m_lo = 0;
         m_z = 0; m_s = 0; m_c = 0;
      end else begin
         m_done = 0;
         if (cd > 0) begin
            cd = cd - 1;
            if (cd == 0) begin
               m_done = 1;
               if (!c_op) begin
                  int p;
                  p = c_a * c_b;
                  m_hi = p / 256; m_lo = p % 256;
                  m_z = (p % 2) == 0; m_s = (p >= 32768); m_c = 0;
               end else begin
                  int dv;
                  dv = c_h * 256 + c_a;
                  m_ovf = (c_h >= c_b);
                  if (m_ovf) begin
                     m_lo = 255; m_hi = c_a;
                  end else begin
                     m_lo = dv / c_b; m_hi = dv % c_b;
                  end
                  m_z = (m_lo == 0); m_s = (m_lo >= 128); m_c = m_ovf;
               end
            end
         end else if (start) begin
            cd = 10;
            c_a = op_a; c_b = op_b; c_h = op_hi; c_op = op_sel;
         end
      end
   end

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (!rst && !ended) begin
         string tr, tz, tsc, tc;
         chk("R7", "busy", busy, cd > 0);
         chk("R7", "done", done, m_done);
         if (m_done && !c_op) begin
            tr = "R1"; tz = "R2"; tsc = "R3"; tc = "R3";
         end else if (m_done && m_ovf) begin
            tr = "R6"; tz = "R5"; tsc = "R5"; tc = "R6";
         end else if (m_done) begin
            tr = "R4"; tz = "R5"; tsc = "R5"; tc = "R6";
         end else begin
            tr = "R10"; tz = "R10"; tsc = "R10"; tc = "R10";
         end
         chk(tr, "res_hi", res_hi, m_hi);
         chk(tr, "res_lo", res_lo, m_lo);
         chk(tz, "flag_z", flag_z, m_z);
         chk(tsc, "flag_s", flag_s, m_s);
         chk(tc, "flag_c", flag_c, m_c);
      end
   end

   task automatic launch(bit op, int a, int b, int h);
      @(negedge clk);
      start = 1'b1; op_sel = op; op_a = 8'(a); op_b = 8'(b); op_hi = 8'(h);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 30; i++) begin
         if (done) break;
         @(negedge clk);
      end
   endtask

   task automatic run_op(bit op, int a, int b, int h);
      launch(op, a, b, h);
      wait_done();
   endtask

   task automatic chk_cleared(string what);
      chk("R9", {what, " busy"}, busy, 0);
      chk("R9", {what, " done"}, done, 0);
      chk("R9", {what, " res"}, {res_hi, res_lo}, 0);
      chk("R9", {what, " flags"}, {flag_z, flag_s, flag_c}, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      chk_cleared("after reset");

      // R1 R2 R3: multiply patterns
      run_op(0, 8'h0F, 8'h10, 0);   // 0x00F0: zero flag set, product nonzero (R2)
      run_op(0, 8'hFF, 8'hFF, 0);   // 0xFE01: sign set (R3)
      run_op(0, 3, 5, 0);
      run_op(0, 0, 8'hA5, 0);
      run_op(0, 8'h80, 2, 0);

      // R4 R5: divide without overflow
      run_op(1, 8'hE8, 7, 8'h03);   // 1000/7 = 142 r 6
      run_op(1, 8'hFF, 1, 0);
      run_op(1, 8'h12, 8'h20, 0);   // quotient 0, zero flag
      run_op(1, 8'hFF, 8'hFF, 8'hFE);

      // R6: overflow and divide by zero
      run_op(1, 8'h34, 0, 8'h12);
      run_op(1, 8'h00, 5, 8'h05);
      chk("R6", "ovf quotient", res_lo, 8'hFF);
      chk("R6", "ovf remainder", res_hi, 8'h00);

      // R8: start while busy is ignored
      launch(0, 3, 5, 0);
      repeat (3) @(negedge clk);
      start = 1'b1; op_sel = 1'b1; op_a = 8'h77; op_b = 8'h09; op_hi = 8'h01;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk("R8", "product after ignored start", {res_hi, res_lo}, 16'h000F);
      @(negedge clk);
      chk("R8", "no relaunch", busy, 0);

      // R7: back-to-back launch right after done
      launch(1, 8'h10, 8'h03, 8'h01);
      wait_done();
      start = 1'b1; op_sel = 1'b0; op_a = 8'h11; op_b = 8'h11;
      @(negedge clk);
      start = 1'b0;
      chk("R7", "relaunch busy", busy, 1);
      wait_done();

      // R9: reset mid-operation
      launch(0, 8'hC3, 8'h5A, 0);
      repeat (4) @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk_cleared("mid-op reset");
      repeat (12) @(negedge clk);
      chk_cleared("idle after reset");

      // mixed pseudo-random operations
      for (int k = 0; k < 80; k++) begin
         bit o;
         int a, b, h;
         o = 1'($urandom_range(0, 1));
         a = $urandom_range(0, 255);
         b = $urandom_range(0, 255);
         h = (k % 3 == 0) ? $urandom_range(0, 255) : $urandom_range(0, 31);
         run_op(o, a, b, h);
      end
      repeat (3) @(negedge clk);

      ended = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule